// File: doc/BRIEF.md
# Banked Internal Data RAM Front End

This block holds the 256-byte internal scratch memory of an 8-bit controller core, together with the access logic the core's operand paths need. One command is taken per clock. It can address a location directly by byte, or through the eight working registers of the currently selected bank. It can read or modify one bit in the bit-addressable window, and it can index memory through one of the bank's two pointer registers. It also keeps the stack pointer used by push and pop operations.

The two bank-select inputs come from the core's status word. Read results appear on a registered output on the cycle after the command. A single-bit write merges the new bit into its byte within the same cycle, so the caller sees one command and not two.

Top module: `idram_front`

## Requirements
- R1: Reset clears rd_valid and sets the stack pointer to 0x07, so the first push after reset stores its byte at address 0x08.
- R2: A register command (op 3 = read, 4 = write) on register number n reaches byte address bank_sel*8 + n, where bank_sel[1] is the upper select bit (status word bit 4) and bank_sel[0] the lower one (status word bit 3).
- R3: Direct commands (op 1 = read, 2 = write) reach any byte address 0x00 to 0xFF through cmd_addr.
- R4: A bit read (op 5) of bit address b returns, on rd_bit, bit b[2:0] of byte 0x20 + b[6:3], and returns that whole byte on rd_data. Example: bit 0x13 is bit 3 of byte 0x22, and bit 0x7F is bit 7 of byte 0x2F.
- R5: A bit write (op 6) stores cmd_wdata[0] into the addressed bit and leaves the other seven bits of that byte unchanged.
- R6: The op code alone decides whether cmd_addr is read as a byte address or as a bit address. The same address value gives different targets under op 1 and op 5.
- R7: Indirect commands (op 7 = read, 8 = write) use as the memory address the byte held in R0 (cmd_reg[0] = 0) or R1 (cmd_reg[0] = 1) of the active bank.
- R8: A push (op 9) first increments the stack pointer modulo 256 and then writes cmd_wdata to the new address, so a push from 0xFF writes address 0x00.
- R9: A pop (op 10) returns the byte at the stack pointer and then decrements the pointer modulo 256, so a pop from 0x00 leaves the pointer at 0xFF.
- R10: A read command (ops 1, 3, 5, 7, 10) with cmd_valid high raises rd_valid, with its data, on the next cycle. Reads see all earlier writes. rd_valid is low after write commands, after op 0, and after any cycle with cmd_valid low. A command presented with cmd_valid low changes neither memory nor the stack pointer.
- R11: Reset leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_addr | input | 8 | Byte address for direct ops, bit address for bit ops |
| cmd_reg | input | 3 | Register number for register ops; bit 0 picks the pointer for indirect ops |
| cmd_wdata | input | 8 | Write data; bit 0 is the value for bit writes |
| bank_sel | input | 2 | Active register bank {upper, lower} select bits |
| rd_valid | output | 1 | Read result valid, one cycle after a read command |
| rd_data | output | 8 | Read byte |
| rd_bit | output | 1 | Addressed bit for bit reads |

## Verification
The bench builds the block with its default parameters: a 256-byte memory, four banks of eight registers, a sixteen-byte bit window at 0x20 and a stack pointer that resets to 0x07. With these values the whole address space can be filled and read back in a few hundred cycles. They also keep the pointer short enough that a run of pushes carries it across 0xFF to 0x00 and a pop carries it back, and they place the first push after reset on R0 of bank 1, which the register path can read back.

// File: rtl/idram_pkg.sv
package idram_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_RD_DIR = 4'd1,
    OP_WR_DIR = 4'd2,
    OP_RD_REG = 4'd3,
    OP_WR_REG = 4'd4,
    OP_RD_BIT = 4'd5,
    OP_WR_BIT = 4'd6,
    OP_RD_IND = 4'd7,
    OP_WR_IND = 4'd8,
    OP_PUSH   = 4'd9,
    OP_POP    = 4'd10
  } idram_op_e;

  localparam int unsigned OP_W = 4;

endpackage

// File: rtl/idram_rst_sync.sv
module idram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/idram_addr_map.sv
module idram_addr_map
  import idram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned REGS_PER_BANK = 8,
  parameter int unsigned BIT_BASE      = 32,
  parameter int unsigned BIT_BYTES     = 16,
  localparam int unsigned BANK_W       = $clog2(NUM_BANKS),
  localparam int unsigned REG_W        = $clog2(REGS_PER_BANK),
  localparam int unsigned POS_W        = $clog2(DATA_W),
  localparam int unsigned BSEL_W       = $clog2(BIT_BYTES)
) (
  input  idram_op_e          op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   regn,
  input  logic [BANK_W-1:0]  bank,
  input  logic [DATA_W-1:0]  ptr,
  input  logic [ADDR_W-1:0]  sp_q,
  output logic [ADDR_W-1:0]  idx_addr,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic [POS_W-1:0]   bit_pos,
  output logic               is_bit,
  output logic               is_read,
  output logic               is_write
);

  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] bit_byte_addr;
  logic [ADDR_W-1:0] ptr_addr;

  // register file: bank in the upper bits, register number below
  assign reg_addr = ADDR_W'({bank, regn});
  // pointer register R0/R1 of the active bank
  assign idx_addr = ADDR_W'({bank, {(REG_W-1){1'b0}}, regn[0]});
  assign ptr_addr = ADDR_W'(ptr);
  assign bit_byte_addr = ADDR_W'(BIT_BASE) + ADDR_W'(addr[POS_W +: BSEL_W]);

  always_comb begin
    eff_addr = addr;
    bit_pos  = '0;
    is_bit   = 1'b0;
    is_read  = 1'b0;
    is_write = 1'b0;
    unique case (op)
      OP_RD_DIR: begin
        is_read = 1'b1;
      end
      OP_WR_DIR: begin
        is_write = 1'b1;
      end
      OP_RD_REG: begin
        eff_addr = reg_addr;
        is_read  = 1'b1;
      end
      OP_WR_REG: begin
        eff_addr = reg_addr;
        is_write = 1'b1;
      end
      OP_RD_BIT: begin
        eff_addr = bit_byte_addr;
        bit_pos  = addr[POS_W-1:0];
        is_bit   = 1'b1;
        is_read  = 1'b1;
      end
      OP_WR_BIT: begin
        eff_addr = bit_byte_addr;
        bit_pos  = addr[POS_W-1:0];
        is_bit   = 1'b1;
        is_write = 1'b1;
      end
      OP_RD_IND: begin
        eff_addr = ptr_addr;
        is_read  = 1'b1;
      end
      OP_WR_IND: begin
        eff_addr = ptr_addr;
        is_write = 1'b1;
      end
      OP_PUSH: begin
        eff_addr = sp_q + ADDR_W'(1);
        is_write = 1'b1;
      end
      OP_POP: begin
        eff_addr = sp_q;
        is_read  = 1'b1;
      end
      default: begin
        eff_addr = addr;
      end
    endcase
  end

endmodule

// File: rtl/idram_stack_ptr.sv
module idram_stack_ptr #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp_q
);

  logic [ADDR_W-1:0] sp_d;
  logic              sp_en;

  assign sp_en = push | pop;

  always_comb begin
    sp_d = sp_q;
    if (push) begin
      sp_d = sp_q + ADDR_W'(1);
    end else if (pop) begin
      sp_d = sp_q - ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= ADDR_W'(SP_RESET);
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  // R8: pre-increment with modulo wrap
  a_r8_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp_q == ADDR_W'($past(sp_q) + ADDR_W'(1))));

  // R9: post-decrement with modulo wrap
  a_r9_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp_q == ADDR_W'($past(sp_q) - ADDR_W'(1))));

  // R10: idle cycles keep the pointer
  a_r10_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q));

endmodule

// File: rtl/idram_store.sv
module idram_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive reset (R11)
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R3: a write is visible at its address on the following cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/idram_front.sv
module idram_front
  import idram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned REGS_PER_BANK = 8,
  parameter int unsigned BIT_BASE      = 32,
  parameter int unsigned BIT_BYTES     = 16,
  parameter int unsigned SP_RESET      = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  input  logic [OP_W-1:0]                  cmd_op,
  input  logic [ADDR_W-1:0]                cmd_addr,
  input  logic [$clog2(REGS_PER_BANK)-1:0] cmd_reg,
  input  logic [DATA_W-1:0]                cmd_wdata,
  input  logic [$clog2(NUM_BANKS)-1:0]     bank_sel,
  output logic                             rd_valid,
  output logic [DATA_W-1:0]                rd_data,
  output logic                             rd_bit
);

  localparam int unsigned POS_W = $clog2(DATA_W);

  idram_op_e         op;
  logic              rst_n_int;
  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [POS_W-1:0]  bit_pos;
  logic              is_bit;
  logic              is_read;
  logic              is_write;
  logic [DATA_W-1:0] ptr_val;
  logic [DATA_W-1:0] byte_val;
  logic [ADDR_W-1:0] sp_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] bit_mask;
  logic              sp_push;
  logic              sp_pop;
  logic              rd_valid_d;
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_bit_d;
  logic              rd_en;

  assign op = idram_op_e'(cmd_op);

  idram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  idram_addr_map #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .NUM_BANKS     (NUM_BANKS),
    .REGS_PER_BANK (REGS_PER_BANK),
    .BIT_BASE      (BIT_BASE),
    .BIT_BYTES     (BIT_BYTES)
  ) u_map (
    .op       (op),
    .addr     (cmd_addr),
    .regn     (cmd_reg),
    .bank     (bank_sel),
    .ptr      (ptr_val),
    .sp_q     (sp_q),
    .idx_addr (idx_addr),
    .eff_addr (eff_addr),
    .bit_pos  (bit_pos),
    .is_bit   (is_bit),
    .is_read  (is_read),
    .is_write (is_write)
  );

  assign sp_push = cmd_valid && (op == OP_PUSH);
  assign sp_pop  = cmd_valid && (op == OP_POP);

  idram_stack_ptr #(
    .ADDR_W   (ADDR_W),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (sp_push),
    .pop   (sp_pop),
    .sp_q  (sp_q)
  );

  // single-cycle read-modify-write merge for bit writes
  assign bit_mask = DATA_W'(1) << bit_pos;
  always_comb begin
    if (is_bit) begin
      wr_data = (byte_val & ~bit_mask) | (cmd_wdata[0] ? bit_mask : '0);
    end else begin
      wr_data = cmd_wdata;
    end
  end

  assign wr_en = cmd_valid && is_write;

  idram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we      (wr_en),
    .waddr   (eff_addr),
    .wdata   (wr_data),
    .raddr_a (idx_addr),
    .rdata_a (ptr_val),
    .raddr_b (eff_addr),
    .rdata_b (byte_val)
  );

  // registered read return
  assign rd_en = cmd_valid && is_read;

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_data;
    rd_bit_d   = rd_bit;
    if (rd_en) begin
      rd_data_d = byte_val;
      rd_bit_d  = byte_val[bit_pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_bit   <= 1'b0;
    end else begin
      rd_valid <= rd_valid_d;
      if (rd_en) begin
        rd_data <= rd_data_d;
        rd_bit  <= rd_bit_d;
      end
    end
  end

  // R5: a bit write differs from the stored byte in at most one bit
  a_r5_one_bit_changed: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && is_bit) |-> ($countones(wr_data ^ byte_val) <= 1));

  // R10: read commands return one cycle later with the addressed byte
  a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_en |=> (rd_valid && (rd_data == $past(byte_val))));

  // R10: nothing returns without a read command
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_en |=> !rd_valid);

  // R10: an unstrobed cycle writes nothing
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cmd_valid |-> !wr_en);

endmodule

// File: tb/idram_front_tb.sv
module idram_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic [7:0] cmd_addr;
  logic [2:0] cmd_reg;
  logic [7:0] cmd_wdata;
  logic [1:0] bank_sel;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_bit;

  int total;
  int bad;
  int cycles;
  int model_mem [256];
  int model_sp;

  idram_front u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .bank_sel  (bank_sel),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_bit    (rd_bit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  // drive one command, step the reference model, sample after the edge
  task automatic cmd(input bit v, input int op, input int addr, input int rn,
                     input int wd, input string req);
    int  ea;
    int  exp_valid;
    int  exp_data;
    int  exp_bit;
    int  bank;
    bank      = int'(bank_sel);
    exp_valid = 0;
    exp_data  = 0;
    exp_bit   = 0;
    cmd_valid = v;
    cmd_op    = 4'(op);
    cmd_addr  = 8'(addr);
    cmd_reg   = 3'(rn);
    cmd_wdata = 8'(wd);
    if (v) begin
      case (op)
        1: begin exp_valid = 1; exp_data = model_mem[addr]; end
        2: model_mem[addr] = wd & 255;
        3: begin exp_valid = 1; exp_data = model_mem[bank*8 + rn]; end
        4: model_mem[bank*8 + rn] = wd & 255;
        5: begin
          ea = 32 + (addr >> 3);
          exp_valid = 1;
          exp_data  = model_mem[ea];
          exp_bit   = (model_mem[ea] >> (addr & 7)) & 1;
        end
        6: begin
          ea = 32 + (addr >> 3);
          model_mem[ea] = (model_mem[ea] & ~(1 << (addr & 7)) & 255)
                        | ((wd & 1) << (addr & 7));
        end
        7: begin exp_valid = 1; exp_data = model_mem[model_mem[bank*8 + (rn & 1)]]; end
        8: model_mem[model_mem[bank*8 + (rn & 1)]] = wd & 255;
        9: begin model_sp = (model_sp + 1) & 255; model_mem[model_sp] = wd & 255; end
        10: begin exp_valid = 1; exp_data = model_mem[model_sp]; model_sp = (model_sp + 255) & 255; end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    check({req, " rd_valid"}, int'(rd_valid), exp_valid);
    if (exp_valid != 0) begin
      check({req, " rd_data"}, int'(rd_data), exp_data);
      if (op == 5) check({req, " rd_bit"}, int'(rd_bit), exp_bit);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    model_sp = 7;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0;
    bad   = 0;
    cmd_valid = 1'b0;
    cmd_op    = '0;
    cmd_addr  = '0;
    cmd_reg   = '0;
    cmd_wdata = '0;
    bank_sel  = 2'd0;
    do_reset();

    // R3: fill whole memory directly, read back a spread of addresses
    for (int a = 0; a < 256; a++) cmd(1, 2, a, 0, (a * 37 + 11) & 255, "R3 fill");

    // R1: first push after reset lands at 0x08 (R0 of bank 1)
    cmd(1, 9, 0, 0, 8'h5A, "R1 first push");
    cmd(1, 1, 8'h08, 0, 0, "R1 push target");
    bank_sel = 2'd1;
    cmd(1, 3, 0, 0, 0, "R1 bank1 R0");

    for (int a = 0; a < 256; a += 17) cmd(1, 1, a, 0, 0, "R3 direct read");
    cmd(1, 1, 255, 0, 0, "R3 top byte");

    // R2: every register of every bank, plus write through bank 2
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int r = 0; r < 8; r++) cmd(1, 3, 0, r, 0, "R2 reg read");
    end
    bank_sel = 2'd2;
    cmd(1, 4, 0, 5, 8'hC3, "R2 reg write");
    cmd(1, 1, 8'h15, 0, 0, "R2 reg alias");
    bank_sel = 2'd0;
    cmd(1, 3, 0, 5, 0, "R2 other bank");

    // R4: bit reads at corners
    cmd(1, 5, 8'h00, 0, 0, "R4 bit 00");
    cmd(1, 5, 8'h07, 0, 0, "R4 bit 07");
    cmd(1, 5, 8'h13, 0, 0, "R4 bit 13");
    cmd(1, 5, 8'h7F, 0, 0, "R4 bit 7F");

    // R5: bit writes touch only the addressed bit
    cmd(1, 2, 8'h22, 0, 8'hA5, "R5 seed");
    cmd(1, 6, 8'h13, 0, 1, "R5 set bit");
    cmd(1, 1, 8'h22, 0, 0, "R5 byte after set");
    cmd(1, 6, 8'h10, 0, 8'hFE, "R5 clear bit");
    cmd(1, 1, 8'h22, 0, 0, "R5 byte after clear");
    cmd(1, 6, 8'h7F, 0, 0, "R5 top bit");
    cmd(1, 1, 8'h2F, 0, 0, "R5 byte 2F");

    // R6: same address value, byte versus bit access
    cmd(1, 1, 8'h13, 0, 0, "R6 byte at 13");
    cmd(1, 5, 8'h13, 0, 0, "R6 bit at 13");

    // R7: indirect through R0 and R1 of bank 1
    bank_sel = 2'd1;
    cmd(1, 4, 0, 0, 8'h40, "R7 set R0");
    cmd(1, 4, 0, 1, 8'hF0, "R7 set R1");
    cmd(1, 8, 0, 0, 8'h3C, "R7 write via R0");
    cmd(1, 1, 8'h40, 0, 0, "R7 direct check");
    cmd(1, 7, 0, 1, 0, "R7 read via R1");
    cmd(1, 7, 0, 6, 0, "R7 read via R0");

    // R8 / R9: stack wrap in both directions
    cmd(1, 9, 0, 0, 8'h11, "R8 push");
    cmd(1, 10, 0, 0, 0, "R9 pop");
    for (int i = 0; i < 247; i++) cmd(1, 9, 0, 0, i & 255, "R8 fill stack");
    cmd(1, 9, 0, 0, 8'h77, "R8 wrap push");
    cmd(1, 1, 8'h00, 0, 0, "R8 wrap target");
    cmd(1, 10, 0, 0, 0, "R9 pop at 00");
    cmd(1, 10, 0, 0, 0, "R9 pop after wrap");

    // R10: unstrobed commands and write/nop cycles return nothing
    cmd(0, 1, 8'h40, 0, 0, "R10 unstrobed read");
    cmd(0, 2, 8'h40, 0, 8'h99, "R10 unstrobed write");
    cmd(0, 9, 0, 0, 8'h99, "R10 unstrobed push");
    cmd(1, 0, 0, 0, 0, "R10 nop");
    cmd(1, 1, 8'h40, 0, 0, "R10 no effect");
    cmd(1, 2, 8'h50, 0, 8'h6E, "R10 write then read");
    cmd(1, 1, 8'h50, 0, 0, "R10 read after write");
    cmd(1, 10, 0, 0, 0, "R10 pointer unchanged");

    // R11: reset keeps memory, restores pointer
    do_reset();
    cmd(1, 1, 8'h50, 0, 0, "R11 kept 50");
    cmd(1, 1, 8'h22, 0, 0, "R11 kept 22");
    cmd(1, 9, 0, 0, 8'hE1, "R1 push after reset");
    cmd(1, 1, 8'h08, 0, 0, "R1 target after reset");

    cmd_valid = 1'b0;
    @(posedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule